// File: doc/BRIEF.md
# Nibble-Bus Memory Write Target

This block is the device side of a 4-bit multiplexed firmware bus, limited to single-byte memory writes. On every rising clock edge it samples a framing strobe (active low) and the shared nibble bus. When a host opens a frame with the memory-cycle start code and then names this device's strapped ID, the block collects a 28-bit address and one data byte. It then runs the two-phase bus turnaround, drives a ready-sync nibble and the closing all-ones nibble, and releases the bus back to the host.

Toward the memory core, the block emits a one-cycle write strobe with the captured address and byte. The byte may be program data or a command; telling those apart is left to the core. If the ID does not match, the size is not single-byte, or the host pulls the framing strobe low before the cycle finishes, the block drops the cycle without touching the bus and without strobing. Clock numbers below count from the last nibble sampled with the strobe low (clock 1).

Top module: `nibble_wr_target`

## Requirements
- R1: While reset is high and on the first cycle after it, `nib_oe` and `wr_stb` are 0.
- R2: A full cycle opened by start code 1110 with a matching ID and size 0000 produces exactly one `wr_stb` pulse, and that pulse occurs in clock 16.
- R3: Only the last nibble sampled while `frm_n` is low counts as the start code. A 1110 followed by a different nibble (both with `frm_n` low) gives no cycle. A different nibble followed by 1110 does give a cycle.
- R4: The nibble in clock 2 must equal `dev_id` for the cycle to be served. On a mismatch, `nib_oe` stays 0 and no strobe is issued.
- R5: Clocks 3 to 9 carry the address, most-significant nibble first. During the strobe, `wr_addr` equals the 28-bit value they form.
- R6: The nibble in clock 10 is the size. Any value other than 0000 abandons the cycle, with no bus drive and no strobe.
- R7: Clock 11 carries data bits 3:0 and clock 12 carries bits 7:4. During the strobe, `wr_data` holds that byte.
- R8: `nib_oe` is 0 in clocks 13 and 14. In clock 15 it is 1 with `nib_out` = 0000. In clock 16 it is 1 with `nib_out` = 1111. It is 0 again from clock 17.
- R9: `wr_stb` is a single-cycle pulse that coincides with the all-ones drive of clock 16.
- R10: If `frm_n` is low in any clock after clock 1, the running cycle is abandoned and `nib_oe` is 0 from the next clock. If that nibble is 1110, it starts a new cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all fields are sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| frm_n | input | 1 | Framing strobe from the host, active low |
| nib_in | input | 4 | Nibble bus as seen by the target |
| dev_id | input | 4 | Strapped device ID |
| nib_out | output | 4 | Nibble driven by the target when enabled |
| nib_oe | output | 1 | Target output enable for the nibble bus |
| wr_stb | output | 1 | One-cycle write strobe to the memory core |
| wr_addr | output | 28 | Captured write address |
| wr_data | output | 8 | Captured write byte |

## Verification
The bench covers several start-code orderings while the strobe is low. A design that latched the first start nibble instead of the last would either serve a frame it should ignore or miss one it should serve. It walks a full cycle clock by clock, so a turnaround that is one cycle off, or a sync value that is wrong, shows up as a drive in clock 14 or 17 or as a bad nibble in clock 15. ID mismatch, non-zero size and a mid-address restart each check that no strobe leaks out. Extreme address and data values catch nibble-order swaps in the address or in the byte.

// File: rtl/nwt_pkg.sv
package nwt_pkg;

    localparam int NIB_W = 4;

    localparam logic [NIB_W-1:0] START_MEM = 4'b1110;
    localparam logic [NIB_W-1:0] SIZE_ONE  = 4'b0000;
    localparam logic [NIB_W-1:0] SYNC_RDY  = 4'b0000;
    localparam logic [NIB_W-1:0] NIB_ONES  = 4'b1111;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_ADDR,
        ST_SIZE,
        ST_DLO,
        ST_DHI,
        ST_TAR0,
        ST_TAR1,
        ST_SYNC,
        ST_TEND
    } nwt_state_e;

    function automatic logic is_mem_start(input logic [NIB_W-1:0] nib);
        return nib == START_MEM;
    endfunction

    function automatic logic target_drives(input nwt_state_e st);
        return (st == ST_SYNC) || (st == ST_TEND);
    endfunction

endpackage

// File: rtl/nwt_seq.sv
module nwt_seq
    import nwt_pkg::*;
#(
    parameter int ADDR_NIBS = 7,
    localparam int CNT_W = (ADDR_NIBS > 1) ? $clog2(ADDR_NIBS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frm_n,
    input  logic [NIB_W-1:0] nib_in,
    input  logic [NIB_W-1:0] dev_id,
    output nwt_state_e       state
);

    nwt_state_e state_nxt;
    logic [CNT_W-1:0] cnt_q, cnt_nxt;

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt_q;
        if (!frm_n) begin
            state_nxt = is_mem_start(nib_in) ? ST_START : ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  state_nxt = ST_IDLE;
                ST_START: begin
                    state_nxt = (nib_in == dev_id) ? ST_ADDR : ST_IDLE;
                    cnt_nxt   = '0;
                end
                ST_ADDR: begin
                    if (cnt_q == CNT_W'(ADDR_NIBS - 1)) state_nxt = ST_SIZE;
                    else                                cnt_nxt   = cnt_q + 1'b1;
                end
                ST_SIZE:  state_nxt = (nib_in == SIZE_ONE) ? ST_DLO : ST_IDLE;
                ST_DLO:   state_nxt = ST_DHI;
                ST_DHI:   state_nxt = ST_TAR0;
                ST_TAR0:  state_nxt = ST_TAR1;
                ST_TAR1:  state_nxt = ST_SYNC;
                ST_SYNC:  state_nxt = ST_TEND;
                ST_TEND:  state_nxt = ST_IDLE;
                default:  state_nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            state <= state_nxt;
            cnt_q <= cnt_nxt;
        end
    end

endmodule

// File: rtl/nwt_capture.sv
module nwt_capture
    import nwt_pkg::*;
#(
    parameter int ADDR_NIBS = 7,
    localparam int ADDR_W = ADDR_NIBS * NIB_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_n,
    input  logic [NIB_W-1:0]  nib_in,
    input  nwt_state_e        state,
    output logic [ADDR_W-1:0] addr,
    output logic [7:0]        data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
            data <= '0;
        end else if (frm_n) begin
            if (state == ST_ADDR) addr <= {addr[ADDR_W-NIB_W-1:0], nib_in};
            if (state == ST_DLO)  data[3:0] <= nib_in;
            if (state == ST_DHI)  data[7:4] <= nib_in;
        end
    end

endmodule

// File: rtl/nwt_drive.sv
module nwt_drive
    import nwt_pkg::*;
(
    input  nwt_state_e       state,
    output logic [NIB_W-1:0] nib_out,
    output logic             nib_oe,
    output logic             wr_stb
);

    always_comb begin
        nib_oe  = target_drives(state);
        nib_out = (state == ST_SYNC) ? SYNC_RDY : NIB_ONES;
        wr_stb  = (state == ST_TEND);
    end

endmodule

// File: rtl/nibble_wr_target.sv
module nibble_wr_target
    import nwt_pkg::*;
#(
    parameter int ADDR_NIBS = 7,
    localparam int ADDR_W = ADDR_NIBS * NIB_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_n,
    input  logic [3:0]        nib_in,
    input  logic [3:0]        dev_id,
    output logic [3:0]        nib_out,
    output logic              nib_oe,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data
);

    nwt_state_e state;

    nwt_seq #(.ADDR_NIBS(ADDR_NIBS)) i_seq (
        .clk    (clk),
        .rst    (rst),
        .frm_n  (frm_n),
        .nib_in (nib_in),
        .dev_id (dev_id),
        .state  (state)
    );

    nwt_capture #(.ADDR_NIBS(ADDR_NIBS)) i_cap (
        .clk    (clk),
        .rst    (rst),
        .frm_n  (frm_n),
        .nib_in (nib_in),
        .state  (state),
        .addr   (wr_addr),
        .data   (wr_data)
    );

    nwt_drive i_drv (
        .state   (state),
        .nib_out (nib_out),
        .nib_oe  (nib_oe),
        .wr_stb  (wr_stb)
    );

endmodule

// File: rtl/nwt_chk.sv
module nwt_chk (
    input logic       clk,
    input logic       rst,
    input logic       frm_n,
    input logic [3:0] nib_out,
    input logic       nib_oe,
    input logic       wr_stb
);

    // R8: the sync nibble is followed by the all-ones nibble unless the frame restarts
    a_r8_sync_then_ones: assert property (@(posedge clk) disable iff (rst)
        (nib_oe && nib_out == 4'b0000 && frm_n) |=> (nib_oe && nib_out == 4'b1111));

    // R8: after the all-ones nibble the bus is released
    a_r8_release: assert property (@(posedge clk) disable iff (rst)
        (nib_oe && nib_out == 4'b1111) |=> !nib_oe);

    // R9: strobe lasts one cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    // R9: strobe coincides with the all-ones drive
    a_r9_stb_with_ones: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> (nib_oe && nib_out == 4'b1111));

    // R2: a strobe is always preceded by the sync nibble
    a_r2_stb_after_sync: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_stb) |-> $past(nib_oe && nib_out == 4'b0000));

    // R10: a low framing strobe frees the bus in the next clock
    a_r10_frame_abort: assert property (@(posedge clk) disable iff (rst)
        !frm_n |=> !nib_oe);

endmodule

bind nibble_wr_target nwt_chk i_nwt_chk (
    .clk     (clk),
    .rst     (rst),
    .frm_n   (frm_n),
    .nib_out (nib_out),
    .nib_oe  (nib_oe),
    .wr_stb  (wr_stb)
);

// File: tb/test_nibble_wr_target.sv
module test_nibble_wr_target;

    logic        clk = 1'b0;
    logic        rst;
    logic        frm_n;
    logic [3:0]  nib_in;
    logic [3:0]  dev_id;
    logic [3:0]  nib_out;
    logic        nib_oe;
    logic        wr_stb;
    logic [27:0] wr_addr;
    logic [7:0]  wr_data;

    int n_vec = 0;
    int n_bad = 0;
    int oe_cnt, stb_cnt;
    logic [27:0] got_addr;
    logic [7:0]  got_data;
    bit done = 0;

    always #2 clk = ~clk;

    nibble_wr_target i_nibble_wr_target (
        .clk(clk), .rst(rst), .frm_n(frm_n), .nib_in(nib_in), .dev_id(dev_id),
        .nib_out(nib_out), .nib_oe(nib_oe), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    // entry: {frm_n, nib_in, exp_oe, exp_out, exp_stb}; one entry per clock
    localparam logic [10:0] VEC [0:18] = '{
        {1'b1, 4'hF, 1'b0, 4'h0, 1'b0},  // idle
        {1'b0, 4'hE, 1'b0, 4'h0, 1'b0},  // clock 1 start
        {1'b1, 4'h3, 1'b0, 4'h0, 1'b0},  // clock 2 id
        {1'b1, 4'hA, 1'b0, 4'h0, 1'b0},  // clock 3 addr msn
        {1'b1, 4'hB, 1'b0, 4'h0, 1'b0},
        {1'b1, 4'hC, 1'b0, 4'h0, 1'b0},
        {1'b1, 4'hD, 1'b0, 4'h0, 1'b0},
        {1'b1, 4'hE, 1'b0, 4'h0, 1'b0},
        {1'b1, 4'h1, 1'b0, 4'h0, 1'b0},
        {1'b1, 4'h2, 1'b0, 4'h0, 1'b0},  // clock 9 addr lsn
        {1'b1, 4'h0, 1'b0, 4'h0, 1'b0},  // clock 10 size
        {1'b1, 4'hA, 1'b0, 4'h0, 1'b0},  // clock 11 data low
        {1'b1, 4'h5, 1'b0, 4'h0, 1'b0},  // clock 12 data high
        {1'b1, 4'hF, 1'b0, 4'h0, 1'b0},  // clock 13 host turnaround
        {1'b1, 4'hF, 1'b0, 4'h0, 1'b0},  // clock 14 float
        {1'b1, 4'hF, 1'b1, 4'h0, 1'b0},  // clock 15 sync
        {1'b1, 4'hF, 1'b1, 4'hF, 1'b1},  // clock 16 ones + strobe
        {1'b1, 4'hF, 1'b0, 4'h0, 1'b0},  // clock 17 released
        {1'b1, 4'hF, 1'b0, 4'h0, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input logic f, input logic [3:0] n);
        @(negedge clk);
        frm_n  = f;
        nib_in = n;
        #1;
        if (nib_oe) oe_cnt++;
        if (wr_stb) begin
            stb_cnt++;
            got_addr = wr_addr;
            got_data = wr_data;
        end
    endtask

    task automatic watch_clear();
        oe_cnt = 0; stb_cnt = 0; got_addr = '0; got_data = '0;
    endtask

    // clocks 2 to 18
    task automatic body(input logic [3:0] id, input logic [27:0] a, input logic [3:0] sz, input logic [7:0] d);
        step(1'b1, id);
        for (int i = 0; i < 7; i++) step(1'b1, a[27-4*i -: 4]);
        step(1'b1, sz);
        step(1'b1, d[3:0]);
        step(1'b1, d[7:4]);
        repeat (6) step(1'b1, 4'hF);
    endtask

    task automatic expect_write(input string req, input logic [27:0] a, input logic [7:0] d);
        chk(stb_cnt == 1, req, 64'(stb_cnt), 64'd1);
        chk(got_addr == a, req, 64'(got_addr), 64'(a));
        chk(got_data == d, req, 64'(got_data), 64'(d));
    endtask

    task automatic expect_none(input string req);
        chk(stb_cnt == 0 && oe_cnt == 0, req, 64'({oe_cnt[15:0], stb_cnt[15:0]}), 64'd0);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; frm_n = 1'b1; nib_in = 4'hF; dev_id = 4'h3;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk(!nib_oe && !wr_stb, "R1 in reset", 64'({nib_oe, wr_stb}), 64'd0);
        rst = 1'b0;
        @(negedge clk); #1;
        chk(!nib_oe && !wr_stb, "R1 after reset", 64'({nib_oe, wr_stb}), 64'd0);

        // table walk: R2 R5 R7 R8 R9
        for (int i = 0; i < 19; i++) begin
            logic [5:0] act, exp;
            @(negedge clk);
            frm_n  = VEC[i][10];
            nib_in = VEC[i][9:6];
            #1;
            exp = VEC[i][5:0];
            act = {nib_oe, nib_oe ? nib_out : 4'h0, wr_stb};
            chk(act == exp, $sformatf("R8/R9 clock %0d", i), 64'(act), 64'(exp));
            if (VEC[i][0]) begin
                chk(wr_addr == 28'hABCDE12, "R5 table addr", 64'(wr_addr), 64'h0ABCDE12);
                chk(wr_data == 8'h5A, "R7 table data", 64'(wr_data), 64'h5A);
            end
        end

        // R2 R5 R7 boundary values
        watch_clear(); step(1'b0, 4'hE); body(4'h3, 28'h0000001, 4'h0, 8'h80);
        expect_write("R5 low addr", 28'h0000001, 8'h80);
        watch_clear(); step(1'b0, 4'hE); body(4'h3, 28'hFFFFFFF, 4'h0, 8'h01);
        expect_write("R7 high addr", 28'hFFFFFFF, 8'h01);
        chk(oe_cnt == 2, "R8 drive clocks", 64'(oe_cnt), 64'd2);

        // R4 mismatch and match with another strap
        watch_clear(); step(1'b0, 4'hE); body(4'h4, 28'h1234567, 4'h0, 8'h11);
        expect_none("R4 id mismatch");
        dev_id = 4'hC;
        watch_clear(); step(1'b0, 4'hE); body(4'hC, 28'h7654321, 4'h0, 8'h22);
        expect_write("R4 id match", 28'h7654321, 8'h22);
        dev_id = 4'h3;

        // R6 size
        watch_clear(); step(1'b0, 4'hE); body(4'h3, 28'h1111111, 4'h1, 8'h33);
        expect_none("R6 size 0001");
        watch_clear(); step(1'b0, 4'hE); body(4'h3, 28'h2222222, 4'h8, 8'h44);
        expect_none("R6 size 1000");

        // R3 last start nibble wins
        watch_clear(); step(1'b0, 4'h2); step(1'b0, 4'hE); body(4'h3, 28'h0A0B0C0, 4'h0, 8'h55);
        expect_write("R3 last is start", 28'h0A0B0C0, 8'h55);
        watch_clear(); step(1'b0, 4'hE); step(1'b0, 4'h2); body(4'h3, 28'h0D0E0F0, 4'h0, 8'h66);
        expect_none("R3 last not start");

        // R10 abandon mid-address
        watch_clear(); step(1'b0, 4'hE); step(1'b1, 4'h3); step(1'b1, 4'h9); step(1'b1, 4'h9);
        step(1'b0, 4'h0);
        repeat (18) step(1'b1, 4'hF);
        expect_none("R10 abort");

        // R10 restart mid-cycle
        watch_clear(); step(1'b0, 4'hE); step(1'b1, 4'h3); step(1'b1, 4'h9); step(1'b1, 4'h9);
        step(1'b0, 4'hE); body(4'h3, 28'h3141592, 4'h0, 8'h77);
        expect_write("R10 restart", 28'h3141592, 8'h77);

        // R10 framing low during sync drops the bus next clock
        watch_clear(); step(1'b0, 4'hE); step(1'b1, 4'h3);
        for (int i = 0; i < 7; i++) step(1'b1, 4'h0);
        step(1'b1, 4'h0); step(1'b1, 4'h1); step(1'b1, 4'h2);
        step(1'b1, 4'hF); step(1'b1, 4'hF); step(1'b0, 4'h0);
        step(1'b1, 4'hF);
        chk(!nib_oe && stb_cnt == 0, "R10 abort in sync", 64'({nib_oe, stb_cnt[7:0]}), 64'd0);
        repeat (4) step(1'b1, 4'hF);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule